// File: doc/BRIEF.md
# Transmit Dominant-State Timeout Guard

This block watches the transmit data line of a single-wire bus transmitter. The line is active low: a low level drives the bus dominant and a high level leaves it recessive. A transmitter that is stuck low, through a software or hardware failure, would otherwise hold the whole bus dominant. The guard stops that from happening.

The guard brings the transmit level into the clock domain and times each low phase. A low phase starts the timer on its falling edge. If the phase lasts the configured number of cycles, the guard latches a fault and withdraws the driver permit so the bus can return to recessive. Only a rising edge on the line clears the fault. A low level that simply continues leaves the fault in place.

The mode controller connects through one qualifier input. The guard acts only while that qualifier is high, and dropping the qualifier clears the timer and the fault. The receive path, the supply-inhibit output and the termination are not touched by this block. They keep running while a fault is latched.

Top module: `txd_dom_guard`

## Requirements
- R1: After reset, `dom_fault` is 0, the timer is idle, and the synchronizer history holds the recessive level (1). With `norm_mode`=1 and `tx_level`=1, `drv_permit` is 1.
- R2: `tx_level` is sampled as low (0 = dominant) for `TIMEOUT_CYC` consecutive synchronized cycles after a falling edge. When that happens, `dom_fault` rises `SYNC_STAGES + TIMEOUT_CYC` clock edges after the first edge that samples the low level. A low phase of `TIMEOUT_CYC - 1` cycles or fewer never sets the fault.
- R3: `drv_permit` is 1 exactly when `norm_mode` is 1 and no fault is latched, and 0 in every other case.
- R4: While the line stays low after a fault, the fault stays set for as long as the low lasts. The timer saturates at `TIMEOUT_CYC` and never wraps.
- R5: A rising edge on the synchronized line clears the fault and returns the timer to zero. A short high pulse between two low phases therefore restarts the count, so two sub-timeout phases never add up to a fault.
- R6: While `norm_mode` is 0, `dom_fault` and `drv_permit` are 0 whatever `tx_level` does. One edge with `norm_mode` at 0 clears the timer, so a partly counted low phase is forgotten.
- R7: If `tx_level` is already low when `norm_mode` rises, the guard treats it as a fresh falling edge and times it. An unconnected line, which is pulled low, therefore ends in a fault and not in an endless dominant.
- R8: An asynchronous reset (`rst_n`=0) clears a latched fault at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | 1 | Transmit data level, asynchronous; 0 = dominant, 1 = recessive |
| norm_mode | input | 1 | Normal-mode qualifier from the mode controller |
| drv_permit | output | 1 | Bus driver may be enabled |
| dom_fault | output | 1 | Dominant timeout fault latched |

## Verification
The main function is exercised with single low phases of many lengths. The set includes the lengths one below, at and one above the timeout, which separates an off-by-one in the counter from a correct limit. Very long phases check that the timer saturates and that the fault holds. Two sub-timeout phases separated by a one-cycle high pulse show whether a rising edge really restarts the count. Toggling the mode qualifier, both in the middle of a count and with the line already low, separates the correct behaviour (clearing, and re-arming on entry) from a guard that ignores the mode or never arms on a level that is already low.

// File: rtl/txg_pkg.sv
package txg_pkg;
   // Line levels of the active-low transmit input
   typedef enum logic {
      LINE_DOM = 1'b0,
      LINE_REC = 1'b1
   } line_t;

   // Edge events on the synchronized line
   typedef struct packed {
      logic fall;
      logic rise;
   } edge_ev_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/txg_sync.sv
module txg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   import txg_pkg::*;

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_sync = d_async;
      end else if (STAGES == 1) begin : g_single
         logic q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r <= LINE_REC;
            else        q_r <= d_async;
         end
         assign q_sync = q_r;
      end else begin : g_chain
         logic [STAGES-1:0] sh_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_r <= {STAGES{LINE_REC}};
            else        sh_r <= {sh_r[STAGES-2:0], d_async};
         end
         assign q_sync = sh_r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/txg_edge.sv
module txg_edge (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              line,
   output txg_pkg::edge_ev_t ev
);
   import txg_pkg::*;

   logic hist_r;

   // History is forced recessive outside normal mode, so a line that is
   // already low on entry shows up as a falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_r <= LINE_REC;
      else if (!active) hist_r <= LINE_REC;
      else              hist_r <= line;
   end

   always_comb begin
      ev.fall = active && (hist_r == LINE_REC) && (line == LINE_DOM);
      ev.rise = active && (hist_r == LINE_DOM) && (line == LINE_REC);
   end

   assert_edge_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev.fall && ev.rise));
endmodule

// File: rtl/txg_timer.sv
module txg_timer #(
   parameter int unsigned LIMIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              line,
   input  txg_pkg::edge_ev_t ev,
   output logic              expired
);
   import txg_pkg::*;

   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] cnt_r;
   logic          armed_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_r   <= '0;
         armed_r <= 1'b0;
      end else if (!active || ev.rise) begin
         cnt_r   <= '0;
         armed_r <= 1'b0;
      end else if (ev.fall) begin
         cnt_r   <= CW'(1);
         armed_r <= 1'b1;
      end else if (armed_r && (cnt_r != LIM_V)) begin
         cnt_r   <= cnt_r + CW'(1);
      end
   end

   assign expired = armed_r && (cnt_r == LIM_V);

   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_r <= LIM_V);
   assert_sat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && active && !ev.rise) |=> expired);
   assert_rise_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev.rise |=> (cnt_r == '0));
   assert_mode_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!armed_r && cnt_r == '0));
   assert_fault_on_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(expired) |-> $past(line == LINE_DOM));
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
   parameter int unsigned TIMEOUT_CYC = 1_700_000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_level,
   input  logic norm_mode,
   output logic drv_permit,
   output logic dom_fault
);
   import txg_pkg::*;

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (SYNC_STAGES > 8) begin : g_bad_sync
         $error("SYNC_STAGES must not exceed 8");
      end
   endgenerate

   logic     tx_s;
   edge_ev_t ev;
   logic     expired;

   txg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (tx_level),
      .q_sync  (tx_s)
   );

   txg_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (norm_mode),
      .line   (tx_s),
      .ev     (ev)
   );

   txg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (norm_mode),
      .line    (tx_s),
      .ev      (ev),
      .expired (expired)
   );

   assign dom_fault  = norm_mode && expired;
   assign drv_permit = norm_mode && !expired;

   assert_permit_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_permit) |-> norm_mode);
   assert_fault_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dom_fault) && norm_mode) |-> $past(tx_s == LINE_REC));
endmodule

// File: tb/sim_txd_dom_guard.sv
module sim_txd_dom_guard;
   localparam int unsigned T  = 16;
   localparam int unsigned NV = 9;
   localparam int unsigned LENS [NV] = '{1, 2, 8, 14, 15, 16, 17, 24, 40};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_level = 1'b1;
   logic norm_mode = 1'b1;
   logic drv_permit, dom_fault;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   txd_dom_guard #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .norm_mode(norm_mode),
      .drv_permit(drv_permit), .dom_fault(dom_fault)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      check(dom_fault, 1'b0, "R1 fault in reset");
      rst_n = 1'b1;
      edges(3);
      check(dom_fault, 1'b0, "R1 fault after reset");
      check(drv_permit, 1'b1, "R1 permit after reset");

      // Vector table: single low phases, fault iff length >= T
      for (int i = 0; i < NV; i++) begin
         tx_level = 1'b0;
         edges(LENS[i]);
         tx_level = 1'b1;
         edges(2);
         check(dom_fault, LENS[i] >= T, $sformatf("R2 fault for low len %0d", LENS[i]));
         check(drv_permit, LENS[i] < T, $sformatf("R3 permit for low len %0d", LENS[i]));
         edges(2);
         check(dom_fault, 1'b0, $sformatf("R5 cleared after len %0d", LENS[i]));
         check(drv_permit, 1'b1, $sformatf("R3 permit restored len %0d", LENS[i]));
         edges(3);
      end

      // R2 exact onset: fault visible after SYNC+T edges
      tx_level = 1'b0;
      edges(T + 1);
      check(dom_fault, 1'b0, "R2 one edge before onset");
      edges(1);
      check(dom_fault, 1'b1, "R2 onset edge");
      // R4: held and saturated over a long low
      edges(3 * T);
      check(dom_fault, 1'b1, "R4 held during long low");
      check(drv_permit, 1'b0, "R3 permit off during fault");
      tx_level = 1'b1;
      edges(4);
      check(dom_fault, 1'b0, "R5 release after long low");

      // R5: one-cycle high between two sub-timeout lows
      tx_level = 1'b0;
      edges(T - 2);
      tx_level = 1'b1;
      edges(1);
      tx_level = 1'b0;
      edges(T - 2);
      tx_level = 1'b1;
      edges(2);
      check(dom_fault, 1'b0, "R5 glitch restarts count");
      edges(4);

      // R6: no fault out of normal mode
      norm_mode = 1'b0;
      tx_level = 1'b0;
      edges(3 * T);
      check(dom_fault, 1'b0, "R6 fault off out of normal");
      check(drv_permit, 1'b0, "R6 permit off out of normal");

      // R7: entering normal with line low arms the timer
      norm_mode = 1'b1;
      edges(T - 1);
      check(dom_fault, 1'b0, "R7 before timeout on entry");
      edges(1);
      check(dom_fault, 1'b1, "R7 timeout for low on entry");

      // R6: leaving normal clears the fault at once
      norm_mode = 1'b0;
      #1;
      check(dom_fault, 1'b0, "R6 fault gated on exit");
      check(drv_permit, 1'b0, "R6 permit gated on exit");
      edges(1);

      // R6: partial count forgotten after a mode drop
      norm_mode = 1'b1;
      edges(T / 2);
      norm_mode = 1'b0;
      edges(1);
      norm_mode = 1'b1;
      edges(T - 1);
      check(dom_fault, 1'b0, "R6 partial count cleared");
      edges(1);
      check(dom_fault, 1'b1, "R6 full timeout after re-entry");

      // R8: reset clears a latched fault
      rst_n = 1'b0;
      #1;
      check(dom_fault, 1'b0, "R8 reset clears fault");
      tx_level = 1'b1;
      edges(2);
      rst_n = 1'b1;
      edges(3);
      check(drv_permit, 1'b1, "R8 permit after reset");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule